// File: doc/BRIEF.md
# Clock Source Control Register Unit

This unit holds the software-visible controls for clock sources in a small microcontroller. Software enables an external crystal oscillator and a PLL, picks the PLL input and multiplier, sets three bus prescalers, and asks for a new system clock source. The unit reports when each source is usable. It sends the decoded settings and the active source select to the clock generation logic. Ready and lock indications come from oscillator and PLL models. Inputs for low-power entry, low-power exit and oscillator failure drive the hardware overrides.

There are two 32-bit registers, a control word and a configuration word, selected by `reg_sel`. Writes take effect at a rising clock edge. Reads are combinational. Some bits are protected: software cannot switch off a source that is driving, or is about to drive, the system clock. The PLL input choice is frozen while the PLL runs. A request to switch the system clock waits until the target source reports ready, and only then does the status field change. Low-power exit, or an oscillator failure seen while the failure monitor is on, makes the internal oscillator the system clock.

Top module: `clk_src_ctl`

## Requirements
- R1: After reset both words read zero and `sysclk_src` is 00. `ahb_shift`, `apb_lo_shift` and `apb_hi_shift` are 0, and `pll_mult` is 2.
- R2: Control bit 17 (external ready) sets at the edge after one where control bit 16 is 1 and `xosc_stable` is 1. Once bit 16 is 0, the flag clears at the sixth rising edge that samples `xosc_tick` high.
- R3: A software write of 0 to control bit 16 is ignored while the external oscillator is in use. In use means the switch field or the status field is 01, or either of them is 10 while configuration bit 16 is 1. A high `lp_entry` clears bit 16 at that edge in every case.
- R4: Control bit 25 (PLL lock) is a registered AND of control bit 24 and `pll_locked`. It is low the cycle after either of them is low.
- R5: A software write of 0 to control bit 24 (PLL enable) is ignored while the switch field or the status field is 10.
- R6: A write to configuration bit 16 (PLL input: 1 = external oscillator) takes effect only when control bit 24 is 0.
- R7: Configuration bits 1:0 request a source: 00 internal, 01 external, 10 PLL. A write of 11 leaves the request unchanged. Status bits 3:2 (and `sysclk_src`) take the request value one edge after an edge where the target is ready. Internal is always ready, external needs control bit 17, and PLL needs control bit 25. Until then the request stays pending.
- R8: On an edge where `lp_exit` is high, the request and status fields become 00, and this overrides a simultaneous write. The same happens when `xosc_fail` is high, control bit 19 (failure monitor) is 1, and the status is 01 or is 10 with configuration bit 16 set.
- R9: Configuration fields are stored as written: AHB code bits 7:4, low APB code bits 10:8, high APB code bits 13:11, multiplier code bits 21:18. `ahb_shift` is 0 for codes 0xxx and is otherwise 1,2,3,4,6,7,8,9 for 1000 through 1111. Each APB shift is 0 for 0xx and is otherwise the low two bits plus 1. `pll_mult` is the code plus 2, with 1111 also giving 16.
- R10: Bits 17, 25 and 3:2 cannot be written, and every bit not named above reads 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | 0 selects the control word, 1 the configuration word |
| wr_en | input | 1 | Write strobe for the selected word |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data of the selected word |
| xosc_stable | input | 1 | External oscillator model reports stable output |
| xosc_tick | input | 1 | One pulse per external oscillator cycle, in this clock domain |
| pll_locked | input | 1 | PLL model reports lock |
| lp_entry | input | 1 | Entry into stop or standby |
| lp_exit | input | 1 | Return from stop or standby |
| xosc_fail | input | 1 | External oscillator failure detected |
| sysclk_src | output | 2 | Source in use: 00 internal, 01 external, 10 PLL |
| xosc_on | output | 1 | External oscillator enable |
| pll_on | output | 1 | PLL enable |
| pll_from_xosc | output | 1 | PLL input is the external oscillator |
| pll_mult | output | 5 | Decoded PLL multiplication factor |
| ahb_shift | output | 4 | AHB division as a power of two |
| apb_lo_shift | output | 3 | Low-speed APB division as a power of two |
| apb_hi_shift | output | 3 | High-speed APB division as a power of two |

## Verification
The assertions assume that `xosc_stable`, `xosc_tick`, `pll_locked` and the event inputs are already synchronous to `clk` and hold steady across each rising edge. They also assume reset is held until the first edge. The stimulus changes every input only on the falling edge. The low-power and failure pulses come at random and are rare, and they may coincide with register writes, so override priority is exercised. A PLL lock indication may appear even while the PLL is off, because the unit must mask it.

// File: rtl/csc_pkg.sv
package csc_pkg;

   typedef enum logic [1:0] {
      SRC_INT = 2'b00,
      SRC_EXT = 2'b01,
      SRC_PLL = 2'b10
   } src_e;

   // control word layout
   localparam int CTL_XEN   = 16;
   localparam int CTL_XRDY  = 17;
   localparam int CTL_MON   = 19;
   localparam int CTL_PEN   = 24;
   localparam int CTL_PLOCK = 25;

   // configuration word layout
   localparam int CFG_SW    = 0;
   localparam int CFG_SWS   = 2;
   localparam int CFG_AHB   = 4;
   localparam int CFG_APBL  = 8;
   localparam int CFG_APBH  = 11;
   localparam int CFG_PSRC  = 16;
   localparam int CFG_MUL   = 18;

   localparam int MIN_DATA_W = CFG_MUL + 4 > CTL_PLOCK + 1 ? CFG_MUL + 4 : CTL_PLOCK + 1;

endpackage

// File: rtl/csc_xosc_ready.sv
module csc_xosc_ready #(
   parameter int HOLD_TICKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic stable,
   input  logic tick,
   output logic rdy
);
   localparam int CNT_W = $clog2(HOLD_TICKS + 1);

   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("HOLD_TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy <= 1'b0;
         cnt <= '0;
      end else if (en) begin
         rdy <= stable;
         cnt <= '0;
      end else if (rdy && tick) begin
         if (cnt == CNT_W'(HOLD_TICKS - 1)) begin
            rdy <= 1'b0;
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R2
   rdy_rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy) |-> $past(en));

   // R2
   hold_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CNT_W'(HOLD_TICKS));

endmodule

// File: rtl/csc_switch.sv
module csc_switch
   import csc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_we,
   input  logic [1:0] req_val,
   input  logic       force_int,
   input  logic       xrdy,
   input  logic       plock,
   output src_e       sw,
   output src_e       sws
);
   logic target_ok;

   always_comb begin
      unique case (sw)
         SRC_EXT: target_ok = xrdy;
         SRC_PLL: target_ok = plock;
         default: target_ok = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw  <= SRC_INT;
         sws <= SRC_INT;
      end else if (force_int) begin
         sw  <= SRC_INT;
         sws <= SRC_INT;
      end else begin
         if (req_we && req_val != 2'b11) sw <= src_e'(req_val);
         if (target_ok) sws <= sw;
      end
   end

   // R7
   status_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sws != $past(sws)) |-> (sws == SRC_INT || sws == $past(sw)));

   // R7
   ext_status_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sws != $past(sws) && sws == SRC_EXT) |-> $past(xrdy));

   // R7
   pll_status_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sws != $past(sws) && sws == SRC_PLL) |-> $past(plock));

   // R8
   forced_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      force_int |=> (sw == SRC_INT && sws == SRC_INT));

endmodule

// File: rtl/csc_decode.sv
module csc_decode (
   input  logic [3:0]      ahb_code,
   input  logic [1:0][2:0] apb_code,
   input  logic [3:0]      mul_code,
   output logic [3:0]      ahb_shift,
   output logic [1:0][2:0] apb_shift,
   output logic [4:0]      mult
);
   always_comb begin
      if (!ahb_code[3])     ahb_shift = 4'd0;
      else if (ahb_code[2]) ahb_shift = {1'b0, ahb_code[2:0]} + 4'd2;
      else                  ahb_shift = {1'b0, ahb_code[2:0]} + 4'd1;
   end

   for (genvar i = 0; i < 2; i++) begin : g_apb
      assign apb_shift[i] = apb_code[i][2] ? ({1'b0, apb_code[i][1:0]} + 3'd1) : 3'd0;
   end

   assign mult = (mul_code == 4'hF) ? 5'd16 : ({1'b0, mul_code} + 5'd2);

   always_comb begin
      // R9
      mult_range_chk: assert (mult >= 5'd2 && mult <= 5'd16);
   end

endmodule

// File: rtl/clk_src_ctl.sv
module clk_src_ctl
   import csc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int HOLD_TICKS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              xosc_stable,
   input  logic              xosc_tick,
   input  logic              pll_locked,
   input  logic              lp_entry,
   input  logic              lp_exit,
   input  logic              xosc_fail,
   output logic [1:0]        sysclk_src,
   output logic              xosc_on,
   output logic              pll_on,
   output logic              pll_from_xosc,
   output logic [4:0]        pll_mult,
   output logic [3:0]        ahb_shift,
   output logic [2:0]        apb_lo_shift,
   output logic [2:0]        apb_hi_shift
);
   if (DATA_W < MIN_DATA_W) begin : g_bad_width
      $error("DATA_W too small for the register layout");
   end

   logic       xen, mon_en, pen, psrc, xrdy, plock;
   logic [3:0] ahb_code, mul_code;
   logic [1:0][2:0] apb_code;
   logic [1:0][2:0] apb_sh;
   src_e       sw, sws;
   logic       ctl_we, cfg_we, xosc_used, pll_used, force_int;
   logic       unused_wdata;

   assign ctl_we = wr_en & ~reg_sel;
   assign cfg_we = wr_en & reg_sel;
   assign unused_wdata = ^wdata;

   assign pll_used  = (sw == SRC_PLL) || (sws == SRC_PLL);
   assign xosc_used = (sw == SRC_EXT) || (sws == SRC_EXT) || (psrc && pll_used);
   assign force_int = lp_exit ||
                      (xosc_fail && mon_en &&
                       (sws == SRC_EXT || (sws == SRC_PLL && psrc)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xen      <= 1'b0;
         mon_en   <= 1'b0;
         pen      <= 1'b0;
         psrc     <= 1'b0;
         ahb_code <= '0;
         apb_code <= '0;
         mul_code <= '0;
         plock    <= 1'b0;
      end else begin
         plock <= pen & pll_locked;
         if (lp_entry)    xen <= 1'b0;
         else if (ctl_we) xen <= wdata[CTL_XEN] | xosc_used;
         if (ctl_we) begin
            mon_en <= wdata[CTL_MON];
            pen    <= wdata[CTL_PEN] | pll_used;
         end
         if (cfg_we) begin
            if (!pen) psrc <= wdata[CFG_PSRC];
            ahb_code    <= wdata[CFG_AHB +: 4];
            apb_code[0] <= wdata[CFG_APBL +: 3];
            apb_code[1] <= wdata[CFG_APBH +: 3];
            mul_code    <= wdata[CFG_MUL +: 4];
         end
      end
   end

   csc_xosc_ready #(.HOLD_TICKS(HOLD_TICKS)) u_xrdy (
      .clk(clk), .rst_n(rst_n), .en(xen), .stable(xosc_stable),
      .tick(xosc_tick), .rdy(xrdy)
   );

   csc_switch u_switch (
      .clk(clk), .rst_n(rst_n), .req_we(cfg_we), .req_val(wdata[CFG_SW +: 2]),
      .force_int(force_int), .xrdy(xrdy), .plock(plock), .sw(sw), .sws(sws)
   );

   csc_decode u_decode (
      .ahb_code(ahb_code), .apb_code(apb_code), .mul_code(mul_code),
      .ahb_shift(ahb_shift), .apb_shift(apb_sh), .mult(pll_mult)
   );

   always_comb begin
      rdata = '0;
      if (!reg_sel) begin
         rdata[CTL_XEN]   = xen;
         rdata[CTL_XRDY]  = xrdy;
         rdata[CTL_MON]   = mon_en;
         rdata[CTL_PEN]   = pen;
         rdata[CTL_PLOCK] = plock;
      end else begin
         rdata[CFG_SW +: 2]   = sw;
         rdata[CFG_SWS +: 2]  = sws;
         rdata[CFG_AHB +: 4]  = ahb_code;
         rdata[CFG_APBL +: 3] = apb_code[0];
         rdata[CFG_APBH +: 3] = apb_code[1];
         rdata[CFG_PSRC]      = psrc;
         rdata[CFG_MUL +: 4]  = mul_code;
      end
   end

   assign sysclk_src    = sws;
   assign xosc_on       = xen;
   assign pll_on        = pen;
   assign pll_from_xosc = psrc;
   assign apb_lo_shift  = apb_sh[0];
   assign apb_hi_shift  = apb_sh[1];

   // R4
   lock_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pen || !pll_locked) |=> !plock);

   // R3
   lp_clears_xen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lp_entry |=> !xen);

   // R6
   psrc_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pen |=> $stable(psrc));

   // R5
   pen_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pen && pll_used) |=> pen);

   // R3
   xen_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xen && xosc_used && !lp_entry) |=> xen);

endmodule

// File: tb/clk_src_ctl_bench.sv
module clk_src_ctl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        xosc_stable = 1'b0, xosc_tick = 1'b0, pll_locked = 1'b0;
   logic        lp_entry = 1'b0, lp_exit = 1'b0, xosc_fail = 1'b0;
   logic [1:0]  sysclk_src;
   logic        xosc_on, pll_on, pll_from_xosc;
   logic [4:0]  pll_mult;
   logic [3:0]  ahb_shift;
   logic [2:0]  apb_lo_shift, apb_hi_shift;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   clk_src_ctl u_clk_src_ctl (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .xosc_stable(xosc_stable), .xosc_tick(xosc_tick),
      .pll_locked(pll_locked), .lp_entry(lp_entry), .lp_exit(lp_exit),
      .xosc_fail(xosc_fail), .sysclk_src(sysclk_src), .xosc_on(xosc_on),
      .pll_on(pll_on), .pll_from_xosc(pll_from_xosc), .pll_mult(pll_mult),
      .ahb_shift(ahb_shift), .apb_lo_shift(apb_lo_shift), .apb_hi_shift(apb_hi_shift)
   );

   // expected-state model built from the requirements
   logic       m_xen, m_mon, m_pen, m_psrc, m_xrdy, m_plock;
   logic [1:0] m_sw, m_sws;
   logic [3:0] m_ahb, m_mul;
   logic [2:0] m_apl, m_aph;
   int         m_cnt;

   function automatic logic [3:0] f_ahb(input logic [3:0] c);
      if (!c[3]) return 4'd0;
      return c[2] ? 4'(c[2:0]) + 4'd2 : 4'(c[2:0]) + 4'd1;
   endfunction

   function automatic logic [2:0] f_apb(input logic [2:0] c);
      return c[2] ? 3'(c[1:0]) + 3'd1 : 3'd0;
   endfunction

   function automatic logic [4:0] f_mul(input logic [3:0] c);
      return (c == 4'hF) ? 5'd16 : 5'(c) + 5'd2;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_xen <= 0; m_mon <= 0; m_pen <= 0; m_psrc <= 0; m_xrdy <= 0; m_plock <= 0;
         m_sw <= 0; m_sws <= 0; m_ahb <= 0; m_mul <= 0; m_apl <= 0; m_aph <= 0; m_cnt <= 0;
      end else begin : upd
         logic pll_sel, ext_use, frc, ok;
         pll_sel = (m_sw == 2'b10) || (m_sws == 2'b10);
         ext_use = (m_sw == 2'b01) || (m_sws == 2'b01) || (m_psrc && pll_sel);
         frc = lp_exit || (xosc_fail && m_mon && (m_sws == 2'b01 || (m_sws == 2'b10 && m_psrc)));
         ok = (m_sw == 2'b01) ? m_xrdy : (m_sw == 2'b10) ? m_plock : 1'b1;
         m_plock <= m_pen && pll_locked;
         if (lp_entry) m_xen <= 0;
         else if (wr_en && !reg_sel) m_xen <= wdata[16] || ext_use;
         if (wr_en && !reg_sel) begin
            m_mon <= wdata[19];
            m_pen <= wdata[24] || pll_sel;
         end
         if (wr_en && reg_sel) begin
            if (!m_pen) m_psrc <= wdata[16];
            m_ahb <= wdata[7:4]; m_apl <= wdata[10:8]; m_aph <= wdata[13:11]; m_mul <= wdata[21:18];
         end
         if (m_xen) begin
            m_xrdy <= xosc_stable; m_cnt <= 0;
         end else if (m_xrdy && xosc_tick) begin
            if (m_cnt == 5) begin m_xrdy <= 0; m_cnt <= 0; end
            else m_cnt <= m_cnt + 1;
         end
         if (frc) begin
            m_sw <= 0; m_sws <= 0;
         end else begin
            if (wr_en && reg_sel && wdata[1:0] != 2'b11) m_sw <= wdata[1:0];
            if (ok) m_sws <= m_sw;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [31:0] v);
      reg_sel = sel;
      #1 v = rdata;
   endtask

   // one clock: wait for the falling edge, then compare against the model
   task automatic step();
      logic [31:0] v, e;
      @(negedge clk);
      #2;
      rd(1'b0, v);
      e = 32'(m_xen) << 16 | 32'(m_xrdy) << 17 | 32'(m_mon) << 19 | 32'(m_pen) << 24 | 32'(m_plock) << 25;
      chk(v == e, "R10 control word (R2 R3 R4 R5)", v, e);
      rd(1'b1, v);
      e = 32'(m_sw) | 32'(m_sws) << 2 | 32'(m_ahb) << 4 | 32'(m_apl) << 8 | 32'(m_aph) << 11
        | 32'(m_psrc) << 16 | 32'(m_mul) << 18;
      chk(v == e, "R10 config word (R6 R7 R9)", v, e);
      chk(sysclk_src == m_sws, "R7 sysclk_src", 32'(sysclk_src), 32'(m_sws));
      chk(xosc_on == m_xen && pll_on == m_pen && pll_from_xosc == m_psrc, "R3 R5 R6 enables",
          {29'd0, xosc_on, pll_on, pll_from_xosc}, {29'd0, m_xen, m_pen, m_psrc});
      chk(ahb_shift == f_ahb(m_ahb) && apb_lo_shift == f_apb(m_apl) && apb_hi_shift == f_apb(m_aph)
          && pll_mult == f_mul(m_mul), "R9 decoded outputs",
          {15'd0, pll_mult, ahb_shift, apb_lo_shift, apb_hi_shift},
          {15'd0, f_mul(m_mul), f_ahb(m_ahb), f_apb(m_apl), f_apb(m_aph)});
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_sel = sel; wr_en = 1'b1; wdata = d;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      if (!done) $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin : main
      logic [31:0] v;
      int seed;
      seed = $urandom(32'h5A17C3);
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      rd(1'b0, v); chk(v == 0, "R1 control after reset", v, 0);
      rd(1'b1, v); chk(v == 0, "R1 config after reset", v, 0);
      chk(sysclk_src == 0 && ahb_shift == 0 && apb_lo_shift == 0 && apb_hi_shift == 0,
          "R1 source and prescalers", {18'd0, sysclk_src, ahb_shift, apb_lo_shift, apb_hi_shift}, 0);
      chk(pll_mult == 5'd2, "R1 multiplier", 32'(pll_mult), 2);
      // R10 read-only and unused bits
      wr(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, v); chk(v == 32'h0109_0000, "R10 control all-ones write", v, 32'h0109_0000);
      wr(1'b0, 32'h0);
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, v); chk(v == 32'h003D_3FF0, "R10 config all-ones write", v, 32'h003D_3FF0);
      chk(ahb_shift == 9 && apb_lo_shift == 4 && apb_hi_shift == 4 && pll_mult == 16,
          "R9 top codes", {15'd0, pll_mult, ahb_shift, apb_lo_shift, apb_hi_shift},
          {15'd0, 5'd16, 4'd9, 3'd4, 3'd4});
      wr(1'b1, 32'h0);
      // R2 ready sets
      xosc_stable = 1'b1;
      wr(1'b0, 32'h0001_0000);
      step();
      rd(1'b0, v); chk(v[17] == 1'b1, "R2 ready set", 32'(v[17]), 1);
      // R7 switch to external
      wr(1'b1, 32'h1);
      step();
      chk(sysclk_src == 2'b01, "R7 switch to external", 32'(sysclk_src), 1);
      // R3 protected clear
      wr(1'b0, 32'h0);
      rd(1'b0, v); chk(v[16] == 1'b1, "R3 clear ignored in use", 32'(v[16]), 1);
      // R9 multiplier code 0111
      wr(1'b1, 32'h0001_0000 | (32'd7 << 18) | 32'h1);
      chk(pll_mult == 5'd9, "R9 multiply by 9", 32'(pll_mult), 9);
      // R4 lock
      pll_locked = 1'b1;
      wr(1'b0, 32'h0101_0000);
      step();
      rd(1'b0, v); chk(v[25] == 1'b1, "R4 lock set", 32'(v[25]), 1);
      // R6 input select frozen, R7 switch to PLL
      wr(1'b1, (32'd7 << 18) | 32'h2);
      chk(pll_from_xosc == 1'b1, "R6 source frozen", 32'(pll_from_xosc), 1);
      step();
      chk(sysclk_src == 2'b10, "R7 switch to PLL", 32'(sysclk_src), 2);
      // R5 protected PLL clear
      wr(1'b0, 32'h0001_0000);
      chk(pll_on == 1'b1, "R5 PLL clear ignored", 32'(pll_on), 1);
      // R4 lock drops
      pll_locked = 1'b0;
      step();
      rd(1'b0, v); chk(v[25] == 1'b0, "R4 lock cleared", 32'(v[25]), 0);
      // R8 failure with monitor on
      pll_locked = 1'b1;
      wr(1'b0, 32'h0109_0000);
      xosc_fail = 1'b1;
      step();
      xosc_fail = 1'b0;
      rd(1'b1, v);
      chk(sysclk_src == 0 && v[1:0] == 0, "R8 failure fallback", {30'd0, sysclk_src}, 0);
      // R7 pending request
      pll_locked = 1'b0;
      step();
      wr(1'b1, 32'h0001_0000 | (32'd7 << 18) | 32'h2);
      step(); step();
      chk(sysclk_src == 0, "R7 request pending", 32'(sysclk_src), 0);
      pll_locked = 1'b1;
      step(); step();
      chk(sysclk_src == 2'b10, "R7 pending completes", 32'(sysclk_src), 2);
      // R8 low-power exit
      lp_exit = 1'b1;
      step();
      lp_exit = 1'b0;
      chk(sysclk_src == 0, "R8 low-power exit", 32'(sysclk_src), 0);
      // R3 low-power entry, R2 hold of six ticks
      lp_entry = 1'b1;
      step();
      lp_entry = 1'b0;
      rd(1'b0, v); chk(v[16] == 1'b0, "R3 entry clears enable", 32'(v[16]), 0);
      xosc_tick = 1'b1;
      for (int i = 0; i < 5; i++) step();
      rd(1'b0, v); chk(v[17] == 1'b1, "R2 ready held after five ticks", 32'(v[17]), 1);
      step();
      rd(1'b0, v); chk(v[17] == 1'b0, "R2 ready clears at sixth tick", 32'(v[17]), 0);
      xosc_tick = 1'b0;
      // R9 mixed prescaler codes
      wr(1'b1, (32'hC << 4) | (32'h4 << 8) | (32'h7 << 11) | (32'd7 << 18));
      chk(ahb_shift == 6 && apb_lo_shift == 1 && apb_hi_shift == 4, "R9 prescaler decode",
          {21'd0, ahb_shift, apb_lo_shift, apb_hi_shift}, {21'd0, 4'd6, 3'd1, 3'd4});
      // random phase
      for (int n = 0; n < 3000; n++) begin
         if ($urandom % 20 == 0) xosc_stable = ~xosc_stable;
         if ($urandom % 20 == 0) pll_locked = ~pll_locked;
         xosc_tick = 1'($urandom % 2);
         lp_entry  = ($urandom % 100) == 0;
         lp_exit   = ($urandom % 100) == 0;
         xosc_fail = ($urandom % 50) == 0;
         if ($urandom % 4 == 0) begin
            if ($urandom % 2 == 0) begin
               v = $urandom;
               v[16] = ($urandom % 10) < 7;
               v[24] = ($urandom % 10) < 7;
               wr(1'b0, v);
            end else begin
               wr(1'b1, $urandom);
            end
         end else begin
            step();
         end
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule